// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block runs one add operation as a series of element steps. It starts from three base register numbers (a destination and two sources), a vector-or-scalar flag for each of those operands, an element count, and an optional predicate mask. It then steps an element index once per clock. On each step it reads two entries of a built-in 32 x 64-bit integer register file, adds them, and writes the sum back. A source flagged as a vector moves one register forward on every step. A source flagged as scalar stays on its base register. The destination follows the same rule.

A cleared predicate bit cancels the write for that element, but the element still counts as a step. A scalar destination stops the run as soon as its first write lands. So a single entry point covers all eight operand-shape combinations: pure scalar, broadcast, reduction-style and full vector forms. `done` marks the end of each run. A side port lets a test environment preload the register file and read it back.

Top module: `vec_loop_seq`

## Requirements
- R1: With `busy` low, a `start` pulse and a nonzero `vecLen` latch every operand input, and `busy` is high in the next cycle. Lengths above 32 are treated as 32.
- R2: Each enabled element step writes `reg[(dst+dOff)%32] = reg[(srcA+aOff)%32] + reg[(srcB+bOff)%32]`, with the sum taken modulo 2^64. One element is handled per clock, and a step reads the results of all earlier steps.
- R3: When `dstVec`=1, the element at index i writes register `(dstBase+i)%32`. Writes come in increasing element order and the run covers elements 0 to VL-1.
- R4: A source whose flag is 1 is read at `(base+i)%32` for element i. A source whose flag is 0 is read at its base register for every element.
- R5: With `predEn`=1, bit i of `predMask` = 0 cancels the write of element i. The element index, and every vector offset, still advance past that element.
- R6: With `predEn`=0, `predMask` has no effect and every element is enabled.
- R7: When `dstVec`=0, the run ends right after the first enabled element writes. If no element is enabled, the run covers all VL elements without writing.
- R8: `done` is high for exactly the one cycle after the final element step, and `busy` is low in that cycle.
- R9: `start` is ignored while `busy` is high. It causes no extra writes and does not change the run in progress.
- R10: A `start` with `vecLen`=0 makes no write. `done` is high in the cycle right after the start edge, and `busy` stays low.
- R11: When no run is writing, `tbWrEn` writes `tbWrData` into register `tbAddr`. `tbRdData` always shows the current content of register `tbAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (only sampled while idle) |
| dstBase | input | 5 | Destination base register |
| srcABase | input | 5 | First source base register |
| srcBBase | input | 5 | Second source base register |
| dstVec | input | 1 | 1: destination steps per element; 0: scalar |
| srcAVec | input | 1 | 1: first source steps per element |
| srcBVec | input | 1 | 1: second source steps per element |
| vecLen | input | 6 | Element count VL (values above 32 act as 32) |
| predMask | input | 32 | Bit i enables element i |
| predEn | input | 1 | 1: use predMask; 0: all elements enabled |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after a run ends |
| wrValid | output | 1 | An element write happens at the coming edge |
| wrAddr | output | 5 | Register written by the current element |
| wrData | output | 64 | Sum written by the current element |
| tbWrEn | input | 1 | Side-port register write |
| tbAddr | input | 5 | Side-port register index |
| tbWrData | input | 64 | Side-port write data |
| tbRdData | output | 64 | Content of register tbAddr |

## Verification
The register file is preloaded with distinct 64-bit values that carry across the 32-bit boundary. A sum therefore shows exactly which two registers were read, and a wrong offset or a lost carry changes the result. Runs are tried with all sources stepping, with one source held scalar, and with both held scalar. Comparing these separates the per-operand stepping rule from a shared index. Sparse masks, and a zero mask with predication off, test that skipped elements still advance the offsets and that the enable switch really bypasses the mask. A scalar destination with its first enabled bit late in the mask, a wrap past register 31, a zero length, a full 32-element run, and a start issued mid-run pin down the run length and the `done` timing.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int REG_COUNT = 32;
  localparam int DATA_W    = 64;
  localparam int MAX_VL    = 32;
  localparam int IDX_W     = $clog2(REG_COUNT);
  localparam int ELEM_W    = $clog2(MAX_VL);
  localparam int VL_W      = $clog2(MAX_VL + 1);

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrAddr;
    logic [IDX_W-1:0] rdAddrA;
    logic [IDX_W-1:0] rdAddrB;
  } strobe_t;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;
endpackage

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IDX_W-1:0]  dstBase,
  input  logic [IDX_W-1:0]  srcABase,
  input  logic [IDX_W-1:0]  srcBBase,
  input  logic              dstVec,
  input  logic              srcAVec,
  input  logic              srcBVec,
  input  logic [VL_W-1:0]   vecLen,
  input  logic [MAX_VL-1:0] predMask,
  input  logic              predEn,
  output strobe_t           strb,
  output logic              busy,
  output logic              done
);
  seq_state_t        state;
  logic [ELEM_W-1:0] elemIdx;
  logic [VL_W-1:0]   lenQ;
  logic [MAX_VL-1:0] maskQ;
  logic [IDX_W-1:0]  dQ, aQ, bQ;
  logic              dV, aV, bV;
  logic              doneQ;

  logic [VL_W-1:0]   lenIn;
  logic              running, elemOn, lastElem, finish;
  logic [IDX_W-1:0]  stepOff;

  // Over-long lengths are clamped to the mask width
  assign lenIn    = (vecLen > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vecLen;
  assign running  = (state == ST_RUN);
  assign elemOn   = maskQ[elemIdx];
  assign lastElem = (VL_W'(elemIdx) + VL_W'(1)) == lenQ;
  assign finish   = running && (lastElem || (elemOn && !dV));
  assign stepOff  = IDX_W'(elemIdx);

  always_comb begin
    strb.wrEn    = running && elemOn;
    strb.wrAddr  = dQ + (dV ? stepOff : '0);
    strb.rdAddrA = aQ + (aV ? stepOff : '0);
    strb.rdAddrB = bQ + (bV ? stepOff : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      elemIdx <= '0;
      lenQ    <= '0;
      maskQ   <= '0;
      dQ      <= '0;
      aQ      <= '0;
      bQ      <= '0;
      dV      <= 1'b0;
      aV      <= 1'b0;
      bV      <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (lenIn == '0) begin
              doneQ <= 1'b1;
            end else begin
              state   <= ST_RUN;
              elemIdx <= '0;
              lenQ    <= lenIn;
              maskQ   <= predEn ? predMask : '1;
              dQ      <= dstBase;
              aQ      <= srcABase;
              bQ      <= srcBBase;
              dV      <= dstVec;
              aV      <= srcAVec;
              bV      <= srcBVec;
            end
          end
        end
        ST_RUN: begin
          if (finish) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else begin
            elemIdx <= elemIdx + ELEM_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = running;
  assign done = doneQ;
endmodule

// File: rtl/vls_dpath.sv
module vls_dpath
  import vls_pkg::*;
(
  input  logic              clk,
  input  strobe_t           strb,
  input  logic              tbWrEn,
  input  logic [IDX_W-1:0]  tbAddr,
  input  logic [DATA_W-1:0] tbWrData,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] tbRdData
);
  logic [DATA_W-1:0] regFile [REG_COUNT];

  assign sum      = regFile[strb.rdAddrA] + regFile[strb.rdAddrB];
  assign tbRdData = regFile[tbAddr];

  // Element writes take priority over the side port
  always_ff @(posedge clk) begin
    if (strb.wrEn)  regFile[strb.wrAddr] <= sum;
    else if (tbWrEn) regFile[tbAddr]     <= tbWrData;
  end
endmodule

// File: rtl/vec_loop_seq.sv
module vec_loop_seq
  import vls_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IDX_W-1:0]  dstBase,
  input  logic [IDX_W-1:0]  srcABase,
  input  logic [IDX_W-1:0]  srcBBase,
  input  logic              dstVec,
  input  logic              srcAVec,
  input  logic              srcBVec,
  input  logic [VL_W-1:0]   vecLen,
  input  logic [MAX_VL-1:0] predMask,
  input  logic              predEn,
  output logic              busy,
  output logic              done,
  output logic              wrValid,
  output logic [IDX_W-1:0]  wrAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic              tbWrEn,
  input  logic [IDX_W-1:0]  tbAddr,
  input  logic [DATA_W-1:0] tbWrData,
  output logic [DATA_W-1:0] tbRdData
);
  strobe_t strb;

  vls_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .dstBase(dstBase), .srcABase(srcABase), .srcBBase(srcBBase),
    .dstVec(dstVec), .srcAVec(srcAVec), .srcBVec(srcBVec),
    .vecLen(vecLen), .predMask(predMask), .predEn(predEn),
    .strb(strb), .busy(busy), .done(done)
  );

  vls_dpath u_dpath (
    .clk(clk), .strb(strb),
    .tbWrEn(tbWrEn), .tbAddr(tbAddr), .tbWrData(tbWrData),
    .sum(wrData), .tbRdData(tbRdData)
  );

  assign wrValid = strb.wrEn;
  assign wrAddr  = strb.wrAddr;
endmodule

// File: rtl/vls_checker.sv
module vls_checker
  import vls_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            wrValid,
  input logic            dstVec,
  input logic [VL_W-1:0] vecLen
);
  logic dVecSeen;

  always_ff @(posedge clk) begin
    if (!rstN)               dVecSeen <= 1'b0;
    else if (start && !busy) dVecSeen <= dstVec;
  end

  p_start_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && vecLen != '0 |=> busy);

  p_write_in_run_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> busy);

  p_scalar_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !dVecSeen |=> done && !busy);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> busy || done);

  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && vecLen == '0 |=> done && !busy);
endmodule

bind vec_loop_seq vls_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .wrValid(wrValid), .dstVec(dstVec), .vecLen(vecLen)
);

// File: tb/vec_loop_seq_test.sv
module vec_loop_seq_test;
  import vls_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [4:0] dstBase = '0, srcABase = '0, srcBBase = '0;
  logic dstVec = 1'b0, srcAVec = 1'b0, srcBVec = 1'b0;
  logic [5:0] vecLen = '0;
  logic [31:0] predMask = '0;
  logic predEn = 1'b0;
  logic busy, done, wrValid;
  logic [4:0] wrAddr;
  logic [63:0] wrData;
  logic tbWrEn = 1'b0;
  logic [4:0] tbAddr = '0;
  logic [63:0] tbWrData = '0;
  logic [63:0] tbRdData;

  always #10 clk = ~clk;

  vec_loop_seq uut (
    .clk(clk), .rstN(rstN), .start(start),
    .dstBase(dstBase), .srcABase(srcABase), .srcBBase(srcBBase),
    .dstVec(dstVec), .srcAVec(srcAVec), .srcBVec(srcBVec),
    .vecLen(vecLen), .predMask(predMask), .predEn(predEn),
    .busy(busy), .done(done), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .tbWrEn(tbWrEn), .tbAddr(tbAddr), .tbWrData(tbWrData), .tbRdData(tbRdData)
  );

  typedef struct packed {
    logic [4:0]  addr;
    logic [63:0] data;
  } wr_item_t;

  wr_item_t   expQ[$];
  logic [63:0] mdl [32];
  string      curReq = "R2";
  int         checks = 0;
  int         fails = 0;
  bit         finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: pops an expected write for every write the design makes
  always @(negedge clk) begin
    if (rstN && wrValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, curReq, "unexpected write addr", 64'(wrAddr), 64'hx);
      end else begin
        wr_item_t it;
        it = expQ.pop_front();
        check(wrAddr == it.addr, curReq, "write addr", 64'(wrAddr), 64'(it.addr));
        check(wrData == it.data, curReq, "write data", wrData, it.data);
      end
    end
  end

  function automatic logic [63:0] seed(input int r);
    return 64'(r) * 64'h0123_4567_89AB_CDEF + 64'hFFFF_FFF0_8000_0001;
  endfunction

  // Driver: builds the expected write list from the requirements, then runs
  task automatic runOp(input int d, input int a, input int b,
                       input bit dv, input bit av, input bit bv,
                       input int vl, input logic [31:0] mask, input bit pen,
                       input string req);
    int steps = 0;
    int effVl = (vl > 32) ? 32 : vl;
    int expCnt;
    int cnt;
    curReq = req;
    for (int i = 0; i < effVl; i++) begin
      bit en = pen ? mask[i] : 1'b1;
      steps = i + 1;
      if (en) begin
        int wd = (d + (dv ? i : 0)) % 32;
        int ra = (a + (av ? i : 0)) % 32;
        int rb = (b + (bv ? i : 0)) % 32;
        wr_item_t it;
        it.addr = 5'(wd);
        it.data = mdl[ra] + mdl[rb];
        mdl[wd] = it.data;
        expQ.push_back(it);
        if (!dv) break;
      end
    end
    expCnt = (effVl == 0) ? 1 : steps + 1;
    dstBase = 5'(d); srcABase = 5'(a); srcBBase = 5'(b);
    dstVec = dv; srcAVec = av; srcBVec = bv;
    vecLen = 6'(vl); predMask = mask; predEn = pen;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    if (effVl != 0) check(busy == 1'b1, "R1", "busy after start", 64'(busy), 64'd1);
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == expCnt, "R8", {req, " done cycle"}, 64'(cnt), 64'(expCnt));
    check(busy == 1'b0, "R8", "busy with done", 64'(busy), 64'd0);
    check(expQ.size() == 0, req, "missing writes", 64'(expQ.size()), 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R8", "done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && wrValid == 1'b0, "R1", "reset state",
          {61'd0, busy, done, wrValid}, 64'd0);
    rstN = 1'b1;
    // R11: preload through the side port
    for (int r = 0; r < 32; r++) begin
      tbWrEn = 1'b1; tbAddr = 5'(r); tbWrData = seed(r); mdl[r] = seed(r);
      @(negedge clk);
    end
    tbWrEn = 1'b0;
    tbAddr = 5'd7;
    #1 check(tbRdData == mdl[7], "R11", "preload readback", tbRdData, mdl[7]);

    runOp(16, 0, 4, 1, 1, 1, 8, 32'h0, 0, "R3");            // all vector
    runOp(8, 2, 20, 1, 0, 1, 5, 32'h0, 0, "R4");            // scalar srcA
    runOp(12, 3, 5, 1, 0, 0, 4, 32'h0, 0, "R4");            // both scalar
    runOp(0, 16, 24, 1, 1, 1, 8, 32'h0000_00A6, 1, "R5");   // sparse mask
    runOp(20, 1, 9, 1, 1, 1, 6, 32'h0, 0, "R6");            // mask ignored
    runOp(5, 10, 18, 0, 1, 1, 8, 32'h0000_0004, 1, "R7");   // scalar dst, late bit
    runOp(6, 11, 12, 0, 1, 0, 8, 32'h0, 0, "R7");           // scalar dst, first elem
    runOp(2, 14, 0, 0, 1, 1, 4, 32'h0, 1, "R7");            // scalar dst, all masked
    runOp(30, 26, 28, 1, 1, 1, 5, 32'h0, 0, "R3");          // wraps past 31
    runOp(9, 1, 2, 1, 1, 1, 0, 32'h0, 0, "R10");            // zero length
    check(busy == 1'b0, "R10", "stays idle", 64'(busy), 64'd0);
    runOp(0, 0, 0, 1, 1, 0, 32, 32'h0, 0, "R2");            // full length, reads own results

    // R9: a second start during a run has no effect
    begin
      int d0 = 24, vl0 = 6;
      int cnt;
      curReq = "R9";
      for (int i = 0; i < vl0; i++) begin
        wr_item_t it;
        it.addr = 5'((d0 + i) % 32);
        it.data = mdl[(4 + i) % 32] + mdl[13];
        mdl[(d0 + i) % 32] = it.data;
        expQ.push_back(it);
      end
      dstBase = 5'(d0); srcABase = 5'd4; srcBBase = 5'd13;
      dstVec = 1; srcAVec = 1; srcBVec = 0; vecLen = 6'(vl0); predEn = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      dstBase = 5'd1; srcABase = 5'd2; vecLen = 6'd3;
      start = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      cnt = 4;
      while (!done && cnt < 100) begin
        @(negedge clk);
        cnt++;
      end
      check(cnt == vl0 + 1, "R9", "done cycle", 64'(cnt), 64'(vl0 + 1));
      check(expQ.size() == 0, "R9", "missing writes", 64'(expQ.size()), 64'd0);
      @(negedge clk);
      @(negedge clk);
      check(busy == 1'b0, "R9", "no second run", 64'(busy), 64'd0);
    end

    // R11: full readback against the model
    for (int r = 0; r < 32; r++) begin
      tbAddr = 5'(r);
      #1 check(tbRdData == mdl[r], "R11", "final readback", tbRdData, mdl[r]);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule